// File: doc/BRIEF.md
# DRAM Command Decoder and Bank Tracker

This block sits behind the control pins of a synchronous DRAM. At each rising clock edge it samples the row strobe, the column strobe and the write enable, all active low. It turns them into activate, read, write, precharge and auto-refresh commands. For each bank it records whether a row is open, and how many cycles have passed since that row was opened. It forwards a column command only when the target bank is open and the row-to-column delay has run out. Any illegal command is dropped, and a one-cycle error flag is raised in its place.

Refresh commands carry no bank number. The block keeps its own refresh counter. The word (row) part forms the low bits of this counter and carries into the bank part. A refresh is accepted only while every bank is precharged. Each accepted refresh shows the counter value it used and then advances the counter. All results are registered, so they appear one cycle after the sampling edge.

Top module: `dram_cmd_tracker`

## Requirements
- R1: While `rst_n` is low at a rising edge, every strobe and error flag clears and every bank becomes precharged. The refresh counter returns to zero, so the first accepted refresh after reset reports row 0 and bank 0.
- R2: The control inputs {ras_n, cas_n, we_n} are decoded as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 auto refresh. Each forwarded command raises exactly one strobe for exactly one cycle, in the cycle after its sampling edge.
- R3: An activate to a precharged bank raises `act_stb`. It marks the bank open in `bank_open`, and it loads `cmd_bank` with the bank and `act_row` with the address.
- R4: An activate to a bank that is already open raises `act_err` and no strobe. `act_row`, `cmd_bank` and `bank_open` keep their values.
- R5: A read or write to an open bank is forwarded (`rd_stb` or `wr_stb`, with `cmd_bank` loaded) only if at least TRCD rising edges separate its sampling edge from that bank's activate edge. An earlier read or write raises `col_err` and is not forwarded.
- R6: A read or write to a precharged bank raises `col_err` and is not forwarded.
- R7: Each bank keeps its own open state and delay count. Column commands may alternate freely among several open banks.
- R8: A precharge closes the selected bank and raises `pre_stb`, which loads `cmd_bank`. Precharging a bank that is already closed is allowed and also raises `pre_stb`.
- R9: An auto refresh with every bank precharged raises `ref_stb`. It presents the counter's row part on `ref_row` and its bank part on `ref_bank`. Afterwards the counter advances by one, with the row part in the low bits, and it wraps at the top. The bank input is ignored.
- R10: An auto refresh while any bank is open raises `ref_err` and no strobe. It leaves the refresh counter unchanged.
- R11: The encodings 111, 110 and 000 change no output and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_sel | input | BANK_W | Bank addressed by the command |
| addr | input | ROW_W | Row address for activate |
| act_stb | output | 1 | Activate forwarded |
| rd_stb | output | 1 | Read forwarded |
| wr_stb | output | 1 | Write forwarded |
| pre_stb | output | 1 | Precharge forwarded |
| ref_stb | output | 1 | Auto refresh forwarded |
| act_err | output | 1 | Activate to an open bank rejected |
| col_err | output | 1 | Read or write rejected |
| ref_err | output | 1 | Refresh with an open bank rejected |
| cmd_bank | output | BANK_W | Bank of the last forwarded activate, column or precharge |
| act_row | output | ROW_W | Row of the last forwarded activate |
| bank_open | output | NUM_BANKS | Open (1) or precharged (0) state per bank |
| ref_row | output | ROW_W | Word address used by the last accepted refresh |
| ref_bank | output | BANK_W | Bank address used by the last accepted refresh |

## Verification
Every strobe, error flag, latched field and refresh address is registered once. Each is due in the cycle right after the rising edge that sampled the command, and `bank_open` changes at that same edge. The bench drives a command at a falling edge and compares every output at the next falling edge. In that way each check sees exactly the result of one sampled command. To pin the row-to-column limit, the bench records the edge number of each activate. It then sweeps the gap to the following read and write across both sides of TRCD. The refresh counter is run through a full wrap in a small configuration.

// File: rtl/dct_pkg.sv
// Shared types for the DRAM command tracker.
// Assumes nothing beyond the control pin encoding held in dct_decode.
package dct_pkg;
    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF
    } cmd_e;
endpackage

// File: rtl/dct_decode.sv
// Combinational decoder from the active-low control pins to a command code.
// Assumes the pins are stable around the sampling edge; unused encodings map to NOP.
module dct_decode
    import dct_pkg::*;
(
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    // Map the three control levels onto one command.
    always_comb begin
        unique case ({ras_n, cas_n, we_n})
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b010:  cmd = CMD_PRE;
            3'b001:  cmd = CMD_REF;
            default: cmd = CMD_NOP;
        endcase
    end
endmodule

// File: rtl/dct_bank_slot.sv
// State of one bank: open flag plus a countdown of the row-to-column delay.
// Assumes open_req is asserted only for a closed bank; open_req wins over close_req.
module dct_bank_slot #(
    parameter int TRCD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open_req,
    input  logic close_req,
    output logic is_open,
    output logic is_ready
);
    localparam int CNT_W = (TRCD > 1) ? $clog2(TRCD) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(TRCD - 1);

    logic [CNT_W-1:0] wait_cnt;

    // Open, close and count down toward column readiness.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open  <= 1'b0;
            wait_cnt <= '0;
        end else if (open_req) begin
            is_open  <= 1'b1;
            wait_cnt <= LOAD;
        end else if (close_req) begin
            is_open  <= 1'b0;
            wait_cnt <= '0;
        end else if (wait_cnt != '0) begin
            wait_cnt <= wait_cnt - 1'b1;
        end
    end

    // Column access allowed once the countdown reaches zero.
    always_comb is_ready = is_open && (wait_cnt == '0);

    AST_OPEN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        open_req |=> is_open); // R3
    AST_CLOSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (close_req && !open_req) |=> !is_open); // R8
    AST_DELAY_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_open && !is_ready && !open_req && !close_req)
        |=> wait_cnt == CNT_W'($past(wait_cnt) - 1'b1)); // R5
endmodule

// File: rtl/dct_refresh.sv
// Internal refresh address counter: row in the low bits carrying into the bank.
// Assumes fire is high only for an accepted refresh; wraps after the last bank.
module dct_refresh #(
    parameter int ROW_W  = 12,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    output logic [ROW_W-1:0]  cur_row,
    output logic [BANK_W-1:0] cur_bank
);
    localparam int W = ROW_W + BANK_W;

    logic [W-1:0] ref_cnt;

    // Advance the counter once per accepted refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt <= '0;
        end else if (fire) begin
            ref_cnt <= ref_cnt + 1'b1;
        end
    end

    // Split the counter into word and bank parts.
    always_comb {cur_bank, cur_row} = ref_cnt;

    AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ref_cnt == W'($past(ref_cnt) + 1'b1)); // R9
    AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(ref_cnt)); // R10
endmodule

// File: rtl/dram_cmd_tracker.sv
// Top: decodes DRAM control pins, checks legality against per-bank state,
// and registers strobes, error flags, latched addresses and refresh addresses.
// Assumes NUM_BANKS is a power of two so every bank_sel value names a bank.
module dram_cmd_tracker
    import dct_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int TRCD      = 3,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BANK_W-1:0]    bank_sel,
    input  logic [ROW_W-1:0]     addr,
    output logic                 act_stb,
    output logic                 rd_stb,
    output logic                 wr_stb,
    output logic                 pre_stb,
    output logic                 ref_stb,
    output logic                 act_err,
    output logic                 col_err,
    output logic                 ref_err,
    output logic [BANK_W-1:0]    cmd_bank,
    output logic [ROW_W-1:0]     act_row,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [ROW_W-1:0]     ref_row,
    output logic [BANK_W-1:0]    ref_bank
);
    cmd_e                 cmd;
    logic [NUM_BANKS-1:0] open_vec;
    logic [NUM_BANKS-1:0] ready_vec;
    logic [ROW_W-1:0]     cnt_row;
    logic [BANK_W-1:0]    cnt_bank;
    logic                 sel_open, sel_ready, is_col;
    logic                 act_ok, act_bad, col_ok, col_bad, ref_ok, ref_bad, pre_go;

    dct_decode u_dec (
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    // One state slot per bank.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic hit;
        always_comb hit = (bank_sel == BANK_W'(g));
        dct_bank_slot #(.TRCD(TRCD)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .open_req  (act_ok && hit),
            .close_req (pre_go && hit),
            .is_open   (open_vec[g]),
            .is_ready  (ready_vec[g])
        );
    end

    dct_refresh #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (ref_ok),
        .cur_row  (cnt_row),
        .cur_bank (cnt_bank)
    );

    // Judge legality of the sampled command against the bank state.
    always_comb begin
        sel_open  = open_vec[bank_sel];
        sel_ready = ready_vec[bank_sel];
        is_col    = (cmd == CMD_RD) || (cmd == CMD_WR);
        act_ok    = (cmd == CMD_ACT) && !sel_open;
        act_bad   = (cmd == CMD_ACT) && sel_open;
        col_ok    = is_col && sel_ready;
        col_bad   = is_col && !sel_ready;
        pre_go    = (cmd == CMD_PRE);
        ref_ok    = (cmd == CMD_REF) && (open_vec == '0);
        ref_bad   = (cmd == CMD_REF) && (open_vec != '0);
    end

    // Register one-cycle strobes and error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_stb <= 1'b0;
            rd_stb  <= 1'b0;
            wr_stb  <= 1'b0;
            pre_stb <= 1'b0;
            ref_stb <= 1'b0;
            act_err <= 1'b0;
            col_err <= 1'b0;
            ref_err <= 1'b0;
        end else begin
            act_stb <= act_ok;
            rd_stb  <= col_ok && (cmd == CMD_RD);
            wr_stb  <= col_ok && (cmd == CMD_WR);
            pre_stb <= pre_go;
            ref_stb <= ref_ok;
            act_err <= act_bad;
            col_err <= col_bad;
            ref_err <= ref_bad;
        end
    end

    // Latch bank, row and refresh addresses of forwarded commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_bank <= '0;
            act_row  <= '0;
            ref_row  <= '0;
            ref_bank <= '0;
        end else begin
            if (act_ok || col_ok || pre_go) cmd_bank <= bank_sel;
            if (act_ok)                     act_row  <= addr;
            if (ref_ok) begin
                ref_row  <= cnt_row;
                ref_bank <= cnt_bank;
            end
        end
    end

    // Expose the bank state.
    always_comb bank_open = open_vec;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_stb, rd_stb, wr_stb, pre_stb, ref_stb, act_err, col_err, ref_err})); // R2
    AST_ACT_LEAVES_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        act_stb |-> bank_open[cmd_bank]); // R3
    AST_ACT_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        act_err |-> $stable(bank_open)); // R4
    AST_COL_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb) |-> bank_open[cmd_bank]); // R5
    AST_REF_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        ref_stb |-> (bank_open == '0)); // R9
    AST_REF_ERR_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        ref_err |-> (bank_open != '0)); // R10
endmodule

// File: tb/sim_dram_cmd_tracker.sv
module sim_dram_cmd_tracker;
    localparam int NB = 4;
    localparam int RW = 3;
    localparam int TR = 3;
    localparam int BW = 2;
    localparam int RMOD = (1 << (RW + BW));

    localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                           C_PRE = 3'b010, C_REF = 3'b001, C_NOP = 3'b111,
                           C_X1 = 3'b110, C_X0 = 3'b000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [BW-1:0] bank_sel = '0;
    logic [RW-1:0] addr = '0;
    logic act_stb, rd_stb, wr_stb, pre_stb, ref_stb, act_err, col_err, ref_err;
    logic [BW-1:0] cmd_bank, ref_bank;
    logic [RW-1:0] act_row, ref_row;
    logic [NB-1:0] bank_open;

    int n_chk = 0, n_fail = 0, edges = 0;
    bit done = 0;

    bit            m_open [NB];
    int            m_edge [NB];
    int            m_ref = 0;
    logic [BW-1:0] m_bank = '0, m_rbank = '0;
    logic [RW-1:0] m_row = '0, m_rrow = '0;

    always #10 clk = ~clk;
    always @(posedge clk) edges++;

    dram_cmd_tracker #(.NUM_BANKS(NB), .ROW_W(RW), .TRCD(TR)) u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .bank_sel(bank_sel), .addr(addr),
        .act_stb(act_stb), .rd_stb(rd_stb), .wr_stb(wr_stb), .pre_stb(pre_stb),
        .ref_stb(ref_stb), .act_err(act_err), .col_err(col_err), .ref_err(ref_err),
        .cmd_bank(cmd_bank), .act_row(act_row), .bank_open(bank_open),
        .ref_row(ref_row), .ref_bank(ref_bank)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NB-1:0] exp_open();
        logic [NB-1:0] v = '0;
        for (int i = 0; i < NB; i++) v[i] = m_open[i];
        return v;
    endfunction

    // Drive one command at a falling edge; compare all outputs one falling edge later.
    task automatic do_cmd(input logic [2:0] rcw, input int b, input int a, input string req);
        int e = edges + 1;
        logic [4:0] es = '0;   // act, rd, wr, pre, ref
        logic [2:0] ee = '0;   // act_err, col_err, ref_err
        bit any_open = 0;
        for (int i = 0; i < NB; i++) any_open |= m_open[i];
        case (rcw)
            C_ACT: if (m_open[b]) ee[2] = 1;
                   else begin
                       es[4] = 1; m_open[b] = 1; m_edge[b] = e;
                       m_bank = BW'(b); m_row = RW'(a);
                   end
            C_RD, C_WR: if (m_open[b] && (e - m_edge[b] >= TR)) begin
                       if (rcw == C_RD) es[3] = 1; else es[2] = 1;
                       m_bank = BW'(b);
                   end else ee[1] = 1;
            C_PRE: begin es[1] = 1; m_open[b] = 0; m_bank = BW'(b); end
            C_REF: if (any_open) ee[0] = 1;
                   else begin
                       es[0] = 1;
                       m_rrow  = RW'(m_ref % (1 << RW));
                       m_rbank = BW'(m_ref / (1 << RW));
                       m_ref   = (m_ref + 1) % RMOD;
                   end
            default: ;
        endcase
        {ras_n, cas_n, we_n} = rcw;
        bank_sel = BW'(b);
        addr = RW'(a);
        @(negedge clk);
        chk(req, "strobes", 32'({act_stb, rd_stb, wr_stb, pre_stb, ref_stb}), 32'(es));
        chk(req, "errors", 32'({act_err, col_err, ref_err}), 32'(ee));
        chk(req, "bank_open", 32'(bank_open), 32'(exp_open()));
        chk(req, "cmd_bank", 32'(cmd_bank), 32'(m_bank));
        chk(req, "act_row", 32'(act_row), 32'(m_row));
        chk(req, "ref_addr", 32'({ref_bank, ref_row}), 32'({m_rbank, m_rrow}));
        {ras_n, cas_n, we_n} = C_NOP;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            {ras_n, cas_n, we_n} = C_NOP;
            @(negedge clk);
            chk("R2", "pulse ended", 32'({act_stb, rd_stb, wr_stb, pre_stb, ref_stb,
                                         act_err, col_err, ref_err}), 32'd0);
        end
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin m_open[i] = 0; m_edge[i] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "strobes", 32'({act_stb, rd_stb, wr_stb, pre_stb, ref_stb}), 32'd0);
        chk("R1", "errors", 32'({act_err, col_err, ref_err}), 32'd0);
        chk("R1", "bank_open", 32'(bank_open), 32'd0);
        rst_n = 1'b1;
        idle(1);

        // R9 and R1: full wrap of the refresh counter, bank input ignored
        for (int i = 0; i <= RMOD; i++) do_cmd(C_REF, i % NB, i % 8, i == 0 ? "R1" : "R9");

        // R11: ignored encodings
        do_cmd(C_X1, 1, 5, "R11");
        do_cmd(C_X0, 2, 6, "R11");
        do_cmd(C_NOP, 3, 7, "R11");

        // R5: sweep activate-to-column gap on every bank
        for (int d = 1; d <= TR + 1; d++) begin
            for (int b = 0; b < NB; b++) begin
                do_cmd(C_ACT, b, (b + d) % 8, "R3");
                idle(d - 1);
                do_cmd(C_RD, b, 0, "R5");
                do_cmd(C_WR, b, 0, "R5");
                do_cmd(C_PRE, b, 0, "R8");
            end
        end

        // R6: column to precharged bank
        do_cmd(C_RD, 2, 0, "R6");
        do_cmd(C_WR, 1, 0, "R6");

        // R7: open all banks, interleave columns
        for (int b = 0; b < NB; b++) do_cmd(C_ACT, b, 7 - b, "R7");
        do_cmd(C_ACT, 0, 3, "R4");
        do_cmd(C_ACT, 3, 1, "R4");
        idle(TR);
        for (int k = 0; k < 12; k++) do_cmd((k % 2) ? C_WR : C_RD, (k * 3) % NB, k, "R7");

        // R10: refresh rejected while banks open
        do_cmd(C_REF, 0, 0, "R10");
        for (int b = 0; b < NB - 1; b++) do_cmd(C_PRE, b, 0, "R8");
        do_cmd(C_REF, 0, 0, "R10");
        do_cmd(C_PRE, NB - 1, 0, "R8");
        do_cmd(C_PRE, NB - 1, 0, "R8");
        do_cmd(C_REF, 2, 0, "R9");
        do_cmd(C_REF, 1, 0, "R9");
        idle(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule